// File: doc/BRIEF.md
# Masked XNOR Correlator Tap Stage

This block is one 32-tap slice of a binary correlator. Every clock a single data bit enters a shift line. Each tap holds a reference bit and a mask bit. A tap scores one when its data bit equals its reference bit and its mask bit is set. The stage counts the scoring taps into a registered 6-bit result. The data bit leaving the far end of the line is presented unregistered, so that several stages can be strung together.

Reference and mask patterns are double buffered. Each pattern is fed in one bit at a time through a serial preload chain, and the bit falling off the end of the reference chain is passed onward to feed the next stage. A synchronous active-low transfer strobe copies both preload chains into the active tap registers in one edge. Data shifting and scoring run on without a pause while new patterns are prepared and swapped in.

A select input chooses where data comes from. It is either a dedicated pin for the first stage of a chain or the data output of the upstream stage.

Top module: `corr_tap_stage`

## Requirements
- R1: A tap adds one to the score exactly when its data bit equals its active reference bit and its active mask bit is 1. The score is the number of such taps.
- R2: An active mask bit of 0 removes its tap from the score whatever the data and reference are. With an all-zero mask the score is 0.
- R3: The score never exceeds 32. With every mask bit 1 and the data equal to the reference in all taps, it reads exactly 32.
- R4: Each clock with `ref_load` high shifts `ref_bit` into reference preload position 0. Every stored bit moves up one position and position 31 is discarded. `ref_out` always shows preload position 31. Without `ref_load` the preload holds.
- R5: Each clock with `mask_load` high shifts `mask_bit` into the mask preload in the same manner as R4. Without `mask_load` the mask preload holds.
- R6: On a clock edge with `xfer_n` low, both preload chains are copied into the active reference and mask registers. With `xfer_n` high the active registers keep their values even while the preload chains change.
- R7: Data shifts one tap every clock, with the newest bit in tap 0. Tap i is compared with preload position i, so the most recently loaded reference and mask bits pair with the newest data bit.
- R8: With `chain_sel` 0 the stage takes `ext_din`. With `chain_sel` 1 it takes `chain_din`, and `ext_din` has no effect.
- R9: `data_out` is the content of tap 31 with no added register. A bit sampled at clock edge k appears on it after edge k+31.
- R10: When a load and a transfer fall on the same edge, the transfer copies the preload contents as they stood before that load.
- R11: The score is registered. The value after edge k is the count over the tap state that held just before edge k.
- R12: While `rst_n` is low at a clock edge, the data line, both preload chains, both active registers and the score are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chain_sel | input | 1 | Data source select: 0 pin, 1 upstream stage |
| ext_din | input | 1 | Data bit from the pin |
| chain_din | input | 1 | Data bit from the upstream stage |
| ref_load | input | 1 | Single-cycle reference shift strobe |
| ref_bit | input | 1 | Serial reference bit |
| mask_load | input | 1 | Single-cycle mask shift strobe |
| mask_bit | input | 1 | Serial mask bit |
| xfer_n | input | 1 | Preload-to-active transfer, active low |
| data_out | output | 1 | Bit in the last data tap |
| ref_out | output | 1 | Bit at the end of the reference preload chain |
| score | output | 6 | Registered count of matching unmasked taps |

## Verification
The bench drives the score to both ends of its range. A full match under an all-ones mask must read 32, so a counter that is too narrow or loses the top tap shows up there. An all-zero mask over matching data must read 0, so a mask that is ignored or inverted shows up there. It aligns a single reference bit, mask bit and data bit at tap 0 and expects a score of exactly one. A design that pairs the newest reference bit with the oldest data tap would read 0 at that point. It changes the preload chains without a transfer and expects the score to stay put, which catches a single-buffered design. It loads and transfers on the same edge and expects the old preload to win. It times a lone data pulse through the line in both select settings, which catches an extra register or a wrong mux leg.

// File: rtl/corr_tap_pkg.sv
// Package: corr_tap_pkg
// Shared constants and helpers for the correlator tap stage.
// Assumes tap counts are at least 2.
package corr_tap_pkg;

    // Default number of taps in one stage
    localparam int unsigned DEF_TAPS = 32;

    // Bits needed to hold a count from 0 up to and including n
    function automatic int unsigned score_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tap_shift_line.sv
// Module: tap_shift_line
// Serial shift register used for the data line and both preload chains.
// A new bit enters position 0 when shift_en is high; the others move up
// by one and the top position is discarded. Assumes synchronous active-low
// reset clears the whole line.
module tap_shift_line #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [N-1:0] bits
);

    // Shift one position towards the top when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (shift_en) begin
            bits <= {bits[N-2:0], bit_in};
        end
    end

endmodule

// File: rtl/tap_active_bank.sv
// Module: tap_active_bank
// Active reference and mask registers of the taps. Both are copied from
// the preload chains on an edge with xfer_n low; otherwise they hold.
// Assumes the preload inputs are the registered chain outputs, so a load
// on the same edge as a transfer is not seen by that transfer.
module tap_active_bank #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer_n,
    input  logic [N-1:0] pre_ref,
    input  logic [N-1:0] pre_mask,
    output logic [N-1:0] act_ref,
    output logic [N-1:0] act_mask
);

    // Copy both preload chains into the active taps on transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ref  <= '0;
            act_mask <= '0;
        end else if (!xfer_n) begin
            act_ref  <= pre_ref;
            act_mask <= pre_mask;
        end
    end

endmodule

// File: rtl/tap_match_count.sv
// Module: tap_match_count
// Per-tap masked equality compare followed by a registered population
// count. Assumes SW is wide enough to hold N.
module tap_match_count #(
    parameter int unsigned N  = 32,
    parameter int unsigned SW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  data,
    input  logic [N-1:0]  ref_bits,
    input  logic [N-1:0]  mask_bits,
    output logic [SW-1:0] score
);

    logic [N-1:0]  hit;
    logic [SW-1:0] count;

    // One masked equality cell per tap
    for (genvar g = 0; g < N; g++) begin : g_cell
        assign hit[g] = (data[g] ~^ ref_bits[g]) & mask_bits[g];
    end

    // Count the taps that scored
    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + SW'(hit[i]);
        end
    end

    // Register the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score <= '0;
        end else begin
            score <= count;
        end
    end

endmodule

// File: rtl/corr_tap_stage.sv
// Module: corr_tap_stage
// One stage of a binary correlator: data shift line, double-buffered
// reference and mask patterns loaded serially, and a registered count of
// matching unmasked taps. Tap 0 holds the newest data bit and pairs with
// the most recently loaded reference and mask bits. Assumes load strobes
// are single-cycle pulses synchronous to clk.
module corr_tap_stage
    import corr_tap_pkg::*;
#(
    parameter int unsigned NTAPS = DEF_TAPS,
    localparam int unsigned SW   = score_width(NTAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_sel,
    input  logic          ext_din,
    input  logic          chain_din,
    input  logic          ref_load,
    input  logic          ref_bit,
    input  logic          mask_load,
    input  logic          mask_bit,
    input  logic          xfer_n,
    output logic          data_out,
    output logic          ref_out,
    output logic [SW-1:0] score
);

    logic             din_sel;
    logic [NTAPS-1:0] data_sr;
    logic [NTAPS-1:0] pre_ref;
    logic [NTAPS-1:0] pre_mask;
    logic [NTAPS-1:0] act_ref;
    logic [NTAPS-1:0] act_mask;

    // Choose the data source for tap 0
    assign din_sel = chain_sel ? chain_din : ext_din;

    tap_shift_line #(.N(NTAPS)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (1'b1),
        .bit_in   (din_sel),
        .bits     (data_sr)
    );

    tap_shift_line #(.N(NTAPS)) u_pre_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (ref_load),
        .bit_in   (ref_bit),
        .bits     (pre_ref)
    );

    tap_shift_line #(.N(NTAPS)) u_pre_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (mask_load),
        .bit_in   (mask_bit),
        .bits     (pre_mask)
    );

    tap_active_bank #(.N(NTAPS)) u_active (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_n   (xfer_n),
        .pre_ref  (pre_ref),
        .pre_mask (pre_mask),
        .act_ref  (act_ref),
        .act_mask (act_mask)
    );

    tap_match_count #(.N(NTAPS), .SW(SW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .data      (data_sr),
        .ref_bits  (act_ref),
        .mask_bits (act_mask),
        .score     (score)
    );

    // Chain outputs are taken straight from the last positions
    assign data_out = data_sr[NTAPS-1];
    assign ref_out  = pre_ref[NTAPS-1];

endmodule

// File: rtl/corr_tap_stage_chk.sv
// Module: corr_tap_stage_chk
// Property checker bound into corr_tap_stage. Observes the internal
// shift lines and active registers and relates them over time.
module corr_tap_stage_chk #(
    parameter int unsigned NTAPS = 32,
    parameter int unsigned SW    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             din_sel,
    input logic             ref_load,
    input logic             ref_bit,
    input logic             mask_load,
    input logic             mask_bit,
    input logic             xfer_n,
    input logic [NTAPS-1:0] data_sr,
    input logic [NTAPS-1:0] pre_ref,
    input logic [NTAPS-1:0] pre_mask,
    input logic [NTAPS-1:0] act_ref,
    input logic [NTAPS-1:0] act_mask,
    input logic [SW-1:0]    score
);

    // R3: score stays inside its range
    a_r3_score_bound: assert property (@(posedge clk) disable iff (!rst_n)
        score <= SW'(NTAPS));

    // R1, R3: full match under full mask yields the maximum score
    a_r1_full_match: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mask == '1 && data_sr == act_ref) |=> (score == SW'(NTAPS)));

    // R2: an all-zero mask yields zero
    a_r2_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_mask == '0) |=> (score == '0));

    // R4: reference preload shifts in the new bit
    a_r4_ref_shift: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load |=> (pre_ref == {$past(pre_ref[NTAPS-2:0]), $past(ref_bit)}));

    // R4: reference preload holds without a strobe
    a_r4_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_load |=> $stable(pre_ref));

    // R5: mask preload shifts in the new bit
    a_r5_mask_shift: assert property (@(posedge clk) disable iff (!rst_n)
        mask_load |=> (pre_mask == {$past(pre_mask[NTAPS-2:0]), $past(mask_bit)}));

    // R5: mask preload holds without a strobe
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_load |=> $stable(pre_mask));

    // R6, R10: transfer copies the preload as it stood before the edge
    a_r6_xfer_copy: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_n |=> (act_ref == $past(pre_ref) && act_mask == $past(pre_mask)));

    // R6: active registers hold without a transfer
    a_r6_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_n |=> ($stable(act_ref) && $stable(act_mask)));

    // R7: data line advances one tap every clock
    a_r7_data_shift: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (data_sr == {$past(data_sr[NTAPS-2:0]), $past(din_sel)}));

endmodule

bind corr_tap_stage corr_tap_stage_chk #(.NTAPS(NTAPS), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din_sel   (din_sel),
    .ref_load  (ref_load),
    .ref_bit   (ref_bit),
    .mask_load (mask_load),
    .mask_bit  (mask_bit),
    .xfer_n    (xfer_n),
    .data_sr   (data_sr),
    .pre_ref   (pre_ref),
    .pre_mask  (pre_mask),
    .act_ref   (act_ref),
    .act_mask  (act_mask),
    .score     (score)
);

// File: tb/corr_tap_stage_tb.sv
`timescale 1ns/1ps
// Bench for corr_tap_stage: directed corner cases plus seeded random
// stimulus, compared each cycle against a bench-side model.
module corr_tap_stage_tb;

    localparam int N  = 32;
    localparam int SW = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, chain_sel, ext_din, chain_din;
    logic          ref_load, ref_bit, mask_load, mask_bit, xfer_n;
    logic          data_out, ref_out;
    logic [SW-1:0] score;

    corr_tap_stage u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .chain_sel (chain_sel),
        .ext_din   (ext_din),
        .chain_din (chain_din),
        .ref_load  (ref_load),
        .ref_bit   (ref_bit),
        .mask_load (mask_load),
        .mask_bit  (mask_bit),
        .xfer_n    (xfer_n),
        .data_out  (data_out),
        .ref_out   (ref_out),
        .score     (score)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Bench model state
    logic [N-1:0]  m_data, m_pref, m_pmask, m_aref, m_amask;
    logic [SW-1:0] m_score;

    // Number of matching unmasked taps
    function automatic int match_count(input logic [N-1:0] d, r, m);
        int c = 0;
        for (int i = 0; i < N; i++) if (d[i] == r[i] && m[i]) c++;
        return c;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, advance model, compare after the edge
    task automatic tick(input logic rn, input logic sel, input logic e, input logic c,
                        input logic rl, input logic rb, input logic ml, input logic mb,
                        input logic xn);
        logic [N-1:0]  n_data, n_pref, n_pmask, n_aref, n_amask;
        logic [SW-1:0] n_score;
        @(negedge clk);
        rst_n = rn; chain_sel = sel; ext_din = e; chain_din = c;
        ref_load = rl; ref_bit = rb; mask_load = ml; mask_bit = mb; xfer_n = xn;
        if (!rn) begin
            n_data = '0; n_pref = '0; n_pmask = '0; n_aref = '0; n_amask = '0; n_score = '0;
        end else begin
            n_score = SW'(match_count(m_data, m_aref, m_amask));
            n_data  = {m_data[N-2:0], sel ? c : e};
            n_pref  = rl ? {m_pref[N-2:0], rb} : m_pref;
            n_pmask = ml ? {m_pmask[N-2:0], mb} : m_pmask;
            n_aref  = !xn ? m_pref  : m_aref;
            n_amask = !xn ? m_pmask : m_amask;
        end
        @(posedge clk);
        #1;
        m_data = n_data; m_pref = n_pref; m_pmask = n_pmask;
        m_aref = n_aref; m_amask = n_amask; m_score = n_score;
        if (rn) begin
            check("R1 R11", "score", int'(score), int'(m_score));
            check("R9", "data_out", int'(data_out), int'(m_data[N-1]));
            check("R4", "ref_out", int'(ref_out), int'(m_pref[N-1]));
        end
    endtask

    // Idle cycle with given pin data
    task automatic idle(input logic e);
        tick(1'b1, 1'b0, e, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    // Load 32 bits into both chains, last bit given separately
    task automatic load_both(input logic rb, input logic mb, input logic rb_last, input logic mb_last);
        for (int i = 0; i < N - 1; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, rb, 1'b1, mb, 1'b1);
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, rb_last, 1'b1, mb_last, 1'b1);
    endtask

    task automatic xfer();
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        int lat;
        seed = $urandom(32'd1234);
        m_data = '0; m_pref = '0; m_pmask = '0; m_aref = '0; m_amask = '0; m_score = '0;

        // R12: reset clears everything
        tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R12", "score after reset", int'(score), 0);
        check("R12", "data_out after reset", int'(data_out), 0);
        check("R12", "ref_out after reset", int'(ref_out), 0);

        // R3: zero reference, full mask, zero data gives the maximum
        load_both(1'b0, 1'b1, 1'b0, 1'b1);
        xfer();
        idle(1'b0);
        idle(1'b0);
        check("R3", "full score", int'(score), 32);

        // R6: new preload without transfer leaves the score alone
        load_both(1'b1, 1'b1, 1'b1, 1'b1);
        idle(1'b0);
        check("R6", "score held without transfer", int'(score), 32);
        check("R4", "ref_out after ones loaded", int'(ref_out), 1);
        xfer();
        idle(1'b0);
        check("R1", "score after mismatching reference", int'(score), 0);

        // R10: load and transfer on one edge take the old preload
        tick(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(1'b0);
        check("R10", "score after load+transfer", int'(score), 0);

        // R2: all-zero mask over matching data
        load_both(1'b0, 1'b0, 1'b0, 1'b0);
        xfer();
        idle(1'b0);
        check("R2", "score with zero mask", int'(score), 0);

        // R7: newest reference/mask bit pairs with newest data tap
        load_both(1'b0, 1'b0, 1'b1, 1'b1);
        xfer();
        idle(1'b1);
        idle(1'b0);
        check("R7", "single aligned match", int'(score), 1);
        idle(1'b0);
        check("R7", "match leaves tap 0", int'(score), 0);

        // R9: pin pulse reaches data_out after 31 more edges
        for (int i = 0; i < N; i++) idle(1'b0);
        idle(1'b1);
        lat = 0;
        while (data_out !== 1'b1 && lat < 40) begin
            idle(1'b0);
            lat++;
        end
        check("R9", "pin pulse latency", lat, N - 1);

        // R8: chain input selected, pin held high has no effect
        for (int i = 0; i < N; i++) tick(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8", "pin ignored when chained", int'(data_out), 0);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        lat = 0;
        while (data_out !== 1'b1 && lat < 40) begin
            tick(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
            lat++;
        end
        check("R8", "chain pulse latency", lat, N - 1);

        // R5 R11: random traffic compared cycle by cycle against the model
        for (int i = 0; i < 4000; i++) begin
            tick(($urandom % 500) != 0,
                 1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom),
                 ($urandom % 8) != 0);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule